// File: doc/BRIEF.md
# Debug Authentication Gate

This block guards the register write port of a debug module. A debugger talks to it through a simple write port and a combinational read port. While the gate is locked, it passes no register writes on to the debug module behind it. To unlock the gate, the debugger reads a challenge word and writes back the sum of that challenge and a secret built into the hardware. The sum wraps at 32 bits. A wrong answer locks the gate again and draws a fresh challenge. A 32-bit maximal-length LFSR supplies each challenge.

The gate owns two registers: a control register and the authentication data register. It also serves a read-only status word. Every other address belongs to the debug module. The gate forwards a write to any other address, one cycle later, only while it is authenticated. The control register stays partly writable while the gate is locked, so that the debugger can reactivate the module.

The gate also keeps two flags for each hart:
- a have-reset flag, which a hart reset event sets and the debugger acknowledges;
- a halted flag.

The status word reports the flags of the hart that the control register selects.

Top module: `dbg_auth_gate`

## Requirements
- R1: After `rst_n` is low, `authenticated` equals the inverse of `REQ_AUTH`, `dm_active` is 0, `hart_sel` is 0, all hart flags are clear, and the challenge is one LFSR step from `SEED`. One step is: shift right by one, then XOR with 0x80200003 if the bit shifted out was 1.
- R2: Reading address `ADDR_AUTH` returns the current challenge. The challenge advances by exactly one LFSR step on a failed answer (R4) and on a module restart (R7). At all other times it holds.
- R3: With `REQ_AUTH`=1, a write to `ADDR_AUTH` whose data equals (challenge + `SECRET`) mod 2^32 sets `authenticated` from the next cycle on.
- R4: With `REQ_AUTH`=1, any other value written to `ADDR_AUTH` clears `authenticated` and advances the challenge. With `REQ_AUTH`=0, writes to `ADDR_AUTH` change nothing.
- R5: The gate owns only `ADDR_CTRL` and `ADDR_AUTH`; every other address is forwarded. While locked, a write to a forwarded address gets an error response and is not forwarded. While authenticated, it appears on `fwd_valid`/`fwd_addr`/`fwd_data` one cycle later with an OK response.
- R6: Control register layout: bit 0 is the module-active bit, bit 1 is the acknowledge-have-reset bit, and bits [SEL_LSB +: HSEL_W] select the hart (SEL_LSB=16 by default). Reads return only the active bit and the hart select. While locked, a control write updates only the active bit.
- R7: A control write that takes the active bit from 0 to 1 restarts the module. `authenticated` returns to the inverse of `REQ_AUTH`, the challenge advances, and `hart_sel` returns to 0. The other fields of the same write then take effect only if the gate is authenticated after the restart.
- R8: A pulse on `hart_rst[h]` sets hart h's have-reset flag and clears its halted flag. A pulse on `halt_evt[h]` sets the halted flag. If both pulse in the same cycle, the reset wins.
- R9: A control write that the gate accepts in full (gate authenticated and active bit 1), with the acknowledge bit set, clears the have-reset flag of the hart that the same write selects. It leaves the other harts' flags unchanged.
- R10: Status read at `ADDR_STAT`:
  - bit 0: `authenticated`;
  - bits 1 and 2: the selected hart's have-reset flag (the "any" and "all" views);
  - bit 3: the selected hart's halted flag;
  - bit 4: the active bit.
- R11: Every write gets exactly one response, with `resp_valid` high in the following cycle. `resp_err` is set only for the rejected writes of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Combinational read data |
| resp_valid | output | 1 | Write response, one cycle after `wr_en` |
| resp_err | output | 1 | Write rejected |
| fwd_valid | output | 1 | Forwarded write strobe to the debug module |
| fwd_addr | output | ADDR_W | Forwarded write address |
| fwd_data | output | 32 | Forwarded write data |
| hart_rst | input | NHARTS | Per-hart reset event pulses |
| halt_evt | input | NHARTS | Per-hart halt event pulses |
| authenticated | output | 1 | Gate is unlocked |
| dm_active | output | 1 | Module-active bit |
| hart_sel | output | HSEL_W | Selected hart |

## Verification
The assertions check the following on every cycle:
- each write gets exactly one response;
- a locked gate never forwards, and a correct answer unlocks it;
- a wrong answer or a restart relocks the gate and moves the challenge, and the challenge never moves at any other time;
- a hart reset always leaves that hart with have-reset set and halted clear.

Only the bench scenarios can show the rest:
- the exact challenge sequence and the wrapped key arithmetic;
- the field layout of the control and status words;
- that an acknowledge clears only the selected hart;
- that a control write while locked changes nothing but the active bit;
- how an instance behaves when authentication is not required.

// File: rtl/dag_pkg.sv
package dag_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [WORD_W-1:0] CHAL_TAPS = 32'h8020_0003;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic ctrl_wr;
    logic ctrl_rise;
    logic ctrl_full;
    logic auth_hit;
    logic auth_miss;
    logic fwd;
    logic reject;
  } wr_dec_t;

  // One Galois step of the challenge LFSR.
  function automatic word_t chal_next(word_t s);
    return (s >> 1) ^ (s[0] ? CHAL_TAPS : '0);
  endfunction

  // Expected answer; the sum wraps at the word width.
  function automatic word_t key_of(word_t ch, word_t secret);
    return ch + secret;
  endfunction
endpackage

// File: rtl/dag_chal_src.sv
module dag_chal_src
  import dag_pkg::*;
#(
  parameter word_t SEED = 32'h1234_5678
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  advance,
  output word_t chal
);
  localparam word_t SEED_SAFE  = (SEED == '0) ? word_t'(1) : SEED;
  localparam word_t CHAL_RESET = chal_next(SEED_SAFE);

  always_ff @(posedge clk) begin
    if (!rst_n)       chal <= CHAL_RESET;
    else if (advance) chal <= chal_next(chal);
  end
endmodule

// File: rtl/dag_wr_policy.sv
module dag_wr_policy
  import dag_pkg::*;
#(
  parameter int unsigned        ADDR_W     = 7,
  parameter logic [ADDR_W-1:0]  ADDR_CTRL  = 7'h10,
  parameter logic [ADDR_W-1:0]  ADDR_AUTH  = 7'h31,
  parameter bit                 REQ_AUTH   = 1'b1,
  parameter word_t              SECRET     = 32'hF00D_BEEF,
  parameter int unsigned        ACTIVE_BIT = 0
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  word_t             wr_data,
  input  logic              authed,
  input  logic              active,
  input  word_t             chal,
  output wr_dec_t           dec
);
  logic is_ctrl, is_auth, key_ok, authed_eff, req;

  always_comb begin
    req        = REQ_AUTH;
    is_ctrl    = (wr_addr == ADDR_CTRL);
    is_auth    = (wr_addr == ADDR_AUTH);
    key_ok     = (wr_data == key_of(chal, SECRET));

    dec.auth_hit  = wr_en & is_auth & req & key_ok;
    dec.auth_miss = wr_en & is_auth & req & ~key_ok;
    dec.ctrl_wr   = wr_en & is_ctrl;
    dec.ctrl_rise = dec.ctrl_wr & wr_data[ACTIVE_BIT] & ~active;
    authed_eff    = dec.ctrl_rise ? ~req : authed;
    dec.ctrl_full = dec.ctrl_wr & wr_data[ACTIVE_BIT] & authed_eff;
    dec.fwd       = wr_en & ~is_ctrl & ~is_auth & authed;
    dec.reject    = wr_en & ~is_ctrl & ~is_auth & ~authed;
  end
endmodule

// File: rtl/dag_hart_flags.sv
module dag_hart_flags #(
  parameter int unsigned NHARTS = 4,
  parameter int unsigned HSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NHARTS-1:0] hart_rst,
  input  logic [NHARTS-1:0] halt_evt,
  input  logic              ack_clr,
  input  logic [HSEL_W-1:0] ack_sel,
  output logic [NHARTS-1:0] have_reset,
  output logic [NHARTS-1:0] halted
);
  for (genvar h = 0; h < NHARTS; h++) begin : g_hart
    logic ack_me;
    assign ack_me = ack_clr && (ack_sel == HSEL_W'(h));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        have_reset[h] <= 1'b0;
        halted[h]     <= 1'b0;
      end else if (hart_rst[h]) begin
        have_reset[h] <= 1'b1;
        halted[h]     <= 1'b0;
      end else begin
        if (ack_me)      have_reset[h] <= 1'b0;
        if (halt_evt[h]) halted[h]     <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbg_auth_gate.sv
module dbg_auth_gate
  import dag_pkg::*;
#(
  parameter int unsigned       NHARTS    = 4,
  parameter int unsigned       ADDR_W    = 7,
  parameter logic [ADDR_W-1:0] ADDR_CTRL = 7'h10,
  parameter logic [ADDR_W-1:0] ADDR_STAT = 7'h11,
  parameter logic [ADDR_W-1:0] ADDR_AUTH = 7'h31,
  parameter bit                REQ_AUTH  = 1'b1,
  parameter word_t             SECRET    = 32'hF00D_BEEF,
  parameter word_t             SEED      = 32'h1234_5678,
  parameter int unsigned       SEL_LSB   = 16,
  localparam int unsigned      HSEL_W    = (NHARTS > 1) ? $clog2(NHARTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              resp_valid,
  output logic              resp_err,
  output logic              fwd_valid,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [31:0]       fwd_data,
  input  logic [NHARTS-1:0] hart_rst,
  input  logic [NHARTS-1:0] halt_evt,
  output logic              authenticated,
  output logic              dm_active,
  output logic [HSEL_W-1:0] hart_sel
);
  localparam int unsigned ACTIVE_BIT = 0;
  localparam int unsigned ACK_BIT    = 1;
  localparam int unsigned SEL_SPAN   = 1 << HSEL_W;
  localparam int unsigned ST_AUTH    = 0;
  localparam int unsigned ST_ANY     = 1;
  localparam int unsigned ST_ALL     = 2;
  localparam int unsigned ST_HALT    = 3;
  localparam int unsigned ST_ACT     = 4;

  // Named internal events, observed by the bound checker.
  wr_dec_t             dec;
  word_t               chal;
  logic                auth_hit, auth_miss, ctrl_rise, chal_adv;
  logic [NHARTS-1:0]   have_reset, halted;
  logic [HSEL_W-1:0]   sel_field;
  logic [SEL_SPAN-1:0] hr_pad, halt_pad;

  assign auth_hit  = dec.auth_hit;
  assign auth_miss = dec.auth_miss;
  assign ctrl_rise = dec.ctrl_rise;
  assign chal_adv  = auth_miss | ctrl_rise;
  assign sel_field = wr_data[SEL_LSB +: HSEL_W];

  dag_wr_policy #(
    .ADDR_W(ADDR_W), .ADDR_CTRL(ADDR_CTRL), .ADDR_AUTH(ADDR_AUTH),
    .REQ_AUTH(REQ_AUTH), .SECRET(SECRET), .ACTIVE_BIT(ACTIVE_BIT)
  ) policy_i (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .authed(authenticated), .active(dm_active), .chal(chal), .dec(dec)
  );

  dag_chal_src #(.SEED(SEED)) chal_i (
    .clk(clk), .rst_n(rst_n), .advance(chal_adv), .chal(chal)
  );

  dag_hart_flags #(.NHARTS(NHARTS), .HSEL_W(HSEL_W)) flags_i (
    .clk(clk), .rst_n(rst_n), .hart_rst(hart_rst), .halt_evt(halt_evt),
    .ack_clr(dec.ctrl_full & wr_data[ACK_BIT]), .ack_sel(sel_field),
    .have_reset(have_reset), .halted(halted)
  );

  // Authentication and control state.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      authenticated <= ~REQ_AUTH;
      dm_active     <= 1'b0;
      hart_sel      <= '0;
    end else begin
      if (dec.ctrl_rise)      authenticated <= ~REQ_AUTH;
      else if (dec.auth_hit)  authenticated <= 1'b1;
      else if (dec.auth_miss) authenticated <= 1'b0;

      if (dec.ctrl_wr) dm_active <= wr_data[ACTIVE_BIT];

      if (dec.ctrl_full)      hart_sel <= sel_field;
      else if (dec.ctrl_rise) hart_sel <= '0;
    end
  end

  // Write response and forwarding stage.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      fwd_valid  <= 1'b0;
      fwd_addr   <= '0;
      fwd_data   <= '0;
    end else begin
      resp_valid <= wr_en;
      resp_err   <= dec.reject;
      fwd_valid  <= dec.fwd;
      if (dec.fwd) begin
        fwd_addr <= wr_addr;
        fwd_data <= wr_data;
      end
    end
  end

  // Read side.
  assign hr_pad   = SEL_SPAN'(have_reset);
  assign halt_pad = SEL_SPAN'(halted);

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_CTRL) begin
      rd_data[ACTIVE_BIT]          = dm_active;
      rd_data[SEL_LSB +: HSEL_W]   = hart_sel;
    end else if (rd_addr == ADDR_STAT) begin
      rd_data[ST_AUTH] = authenticated;
      rd_data[ST_ANY]  = hr_pad[hart_sel];
      rd_data[ST_ALL]  = hr_pad[hart_sel];
      rd_data[ST_HALT] = halt_pad[hart_sel];
      rd_data[ST_ACT]  = dm_active;
    end else if (rd_addr == ADDR_AUTH) begin
      rd_data = chal;
    end
  end
endmodule

// File: rtl/dbg_auth_gate_chk.sv
module dbg_auth_gate_chk #(
  parameter int unsigned       NHARTS    = 4,
  parameter int unsigned       ADDR_W    = 7,
  parameter logic [ADDR_W-1:0] ADDR_CTRL = 7'h10,
  parameter logic [ADDR_W-1:0] ADDR_AUTH = 7'h31,
  parameter bit                REQ_AUTH  = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              resp_valid,
  input logic              resp_err,
  input logic              fwd_valid,
  input logic              authenticated,
  input logic [31:0]       chal,
  input logic              auth_hit,
  input logic              auth_miss,
  input logic              ctrl_rise,
  input logic [NHARTS-1:0] hart_rst,
  input logic [NHARTS-1:0] have_reset,
  input logic [NHARTS-1:0] halted
);
  logic req;
  assign req = REQ_AUTH;

  a_r11_resp_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> resp_valid);
  a_r11_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !resp_valid);
  a_r5_locked_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !authenticated && wr_addr != ADDR_CTRL && wr_addr != ADDR_AUTH)
      |=> (resp_err && !fwd_valid));
  a_r5_err_never_forwards: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> !fwd_valid);
  a_r3_hit_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    auth_hit |=> authenticated);
  a_r4_miss_relocks: assert property (@(posedge clk) disable iff (!rst_n)
    auth_miss |=> (!authenticated && chal != $past(chal)));
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rise |=> (authenticated == !req && chal != $past(chal)));
  a_r2_chal_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(auth_miss || ctrl_rise) |=> $stable(chal));
  a_r2_chal_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    chal != '0);

  for (genvar h = 0; h < NHARTS; h++) begin : g_hart_chk
    a_r8_reset_marks: assert property (@(posedge clk) disable iff (!rst_n)
      hart_rst[h] |=> (have_reset[h] && !halted[h]));
  end
endmodule

bind dbg_auth_gate dbg_auth_gate_chk #(
  .NHARTS(NHARTS), .ADDR_W(ADDR_W), .ADDR_CTRL(ADDR_CTRL),
  .ADDR_AUTH(ADDR_AUTH), .REQ_AUTH(REQ_AUTH)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .resp_valid(resp_valid), .resp_err(resp_err), .fwd_valid(fwd_valid),
  .authenticated(authenticated), .chal(chal), .auth_hit(auth_hit),
  .auth_miss(auth_miss), .ctrl_rise(ctrl_rise), .hart_rst(hart_rst),
  .have_reset(have_reset), .halted(halted)
);

// File: tb/dbg_auth_gate_tb_top.sv
`timescale 1ns/1ps
module dbg_auth_gate_tb_top;
  localparam int          N      = 4;
  localparam int          AW     = 7;
  localparam logic [6:0]  A_CTRL = 7'h10;
  localparam logic [6:0]  A_STAT = 7'h11;
  localparam logic [6:0]  A_AUTH = 7'h31;
  localparam logic [31:0] SEC    = 32'hF00D_BEEF;
  localparam logic [31:0] SD     = 32'h1234_5678;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [N-1:0] hart_rst = '0, halt_evt = '0;

  logic [31:0] rd_data, fwd_data, rd_data_o, fwd_data_o;
  logic [AW-1:0] fwd_addr, fwd_addr_o;
  logic resp_valid, resp_err, fwd_valid, authenticated, dm_active;
  logic resp_valid_o, resp_err_o, fwd_valid_o, authenticated_o, dm_active_o;
  logic [1:0] hart_sel, hart_sel_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_ch, open_ch;
  bit done = 0;

  always #4 clk = ~clk;

  dbg_auth_gate #(.NHARTS(N), .REQ_AUTH(1'b1), .SECRET(SEC), .SEED(SD)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .resp_valid(resp_valid), .resp_err(resp_err),
    .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_data(fwd_data),
    .hart_rst(hart_rst), .halt_evt(halt_evt), .authenticated(authenticated),
    .dm_active(dm_active), .hart_sel(hart_sel));

  dbg_auth_gate #(.NHARTS(N), .REQ_AUTH(1'b0), .SECRET(SEC), .SEED(SD)) dut_open_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data_o), .resp_valid(resp_valid_o), .resp_err(resp_err_o),
    .fwd_valid(fwd_valid_o), .fwd_addr(fwd_addr_o), .fwd_data(fwd_data_o),
    .hart_rst(hart_rst), .halt_evt(halt_evt), .authenticated(authenticated_o),
    .dm_active(dm_active_o), .hart_sel(hart_sel_o));

  function automatic logic [31:0] step(logic [31:0] s);
    logic [31:0] r;
    r = {1'b0, s[31:1]};
    if (s[0]) r = r ^ 32'h8020_0003;
    return r;
  endfunction

  function automatic logic [31:0] stat(bit au, bit hr, bit hl, bit ac);
    return (32'(ac) << 4) | (32'(hl) << 3) | (32'(hr) << 2) | (32'(hr) << 1) | 32'(au);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] v, output logic [31:0] vo);
    rd_addr = a;
    #1;
    v = rd_data; vo = rd_data_o;
  endtask

  task automatic pulse(logic [N-1:0] r, logic [N-1:0] h);
    @(negedge clk);
    hart_rst = r; halt_evt = h;
    @(negedge clk);
    hart_rst = '0; halt_evt = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v, vo;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    exp_ch = step(SD); open_ch = step(SD);

    // R1 reset state
    check("R1 auth locked", 32'(authenticated), 0);
    check("R1 open auth", 32'(authenticated_o), 1);
    check("R1 active", 32'(dm_active), 0);
    rd(A_AUTH, v, vo);
    check("R1 R2 challenge", v, exp_ch);
    check("R1 open challenge", vo, open_ch);
    rd(A_STAT, v, vo);
    check("R1 R10 status", v, stat(0, 0, 0, 0));

    // R5 locked sweep over every forwarded address
    for (int a = 0; a < 128; a++) begin
      if (a == int'(A_CTRL) || a == int'(A_AUTH)) continue;
      wr(AW'(a), 32'(a) * 32'h0101_0101);
      check("R5 R11 locked resp", {resp_valid, resp_err, fwd_valid}, 3'b110);
      check("R5 open forwards", {fwd_valid_o, resp_err_o, fwd_addr_o}, {2'b10, AW'(a)});
    end

    // R6 R7 locked control write with rising active: restart, fields dropped
    wr(A_CTRL, 32'h0003_0003);
    exp_ch = step(exp_ch); open_ch = step(open_ch);
    check("R11 ctrl resp", {resp_valid, resp_err}, 2'b10);
    rd(A_CTRL, v, vo);
    check("R6 R7 locked ctrl", v, 32'h1);
    check("R7 open ctrl applied", vo, 32'h0003_0001);
    rd(A_AUTH, v, vo);
    check("R7 challenge advanced", v, exp_ch);
    check("R7 open challenge advanced", vo, open_ch);
    check("R7 still locked", 32'(authenticated), 0);

    // R6 locked, already active: hart select ignored
    wr(A_CTRL, 32'h0002_0001);
    rd(A_CTRL, v, vo);
    check("R6 locked sel ignored", v, 32'h1);
    rd(A_AUTH, v, vo);
    check("R2 no advance", v, exp_ch);

    // R4 wrong answer
    wr(A_AUTH, exp_ch + SEC + 32'h1);
    exp_ch = step(exp_ch);
    check("R4 resp ok", {resp_valid, resp_err}, 2'b10);
    check("R4 locked", 32'(authenticated), 0);
    rd(A_AUTH, v, vo);
    check("R4 R2 new challenge", v, exp_ch);
    check("R4 open unchanged", vo, open_ch);
    check("R4 open still auth", 32'(authenticated_o), 1);

    // R3 correct answer, wrapping add
    wr(A_AUTH, exp_ch + SEC);
    check("R3 unlocked", 32'(authenticated), 1);
    rd(A_AUTH, v, vo);
    check("R3 R2 challenge held", v, exp_ch);

    // R5 authenticated forwarding sweep
    for (int a = 0; a < 128; a++) begin
      if (a == int'(A_CTRL) || a == int'(A_AUTH)) continue;
      wr(AW'(a), ~(32'(a) << 8));
      check("R5 fwd", {fwd_valid, resp_err, fwd_addr}, {2'b10, AW'(a)});
      check("R5 fwd data", fwd_data, ~(32'(a) << 8));
    end

    // R8 R10 per-hart halt then reset, then simultaneous pulses
    for (int h = 0; h < N; h++) begin
      pulse('0, N'(1) << h);
      wr(A_CTRL, 32'(h) << 16 | 32'h1);
      check("R6 sel", 32'(hart_sel), 32'(h));
      rd(A_STAT, v, vo);
      check("R8 halted", v, stat(1, 0, 1, 1));
      pulse(N'(1) << h, '0);
      rd(A_STAT, v, vo);
      check("R8 R10 have reset", v, stat(1, 1, 0, 1));
      pulse('0, N'(1) << h);
      pulse(N'(1) << h, N'(1) << h);
      rd(A_STAT, v, vo);
      check("R8 reset wins", v, stat(1, 1, 0, 1));
    end

    // R9 acknowledge clears only the selected hart
    for (int h = 0; h < N; h++) begin
      wr(A_CTRL, 32'(h) << 16 | 32'h3);
      rd(A_STAT, v, vo);
      check("R9 ack clears", v, stat(1, 0, 0, 1));
      if (h + 1 < N) begin
        wr(A_CTRL, 32'(h + 1) << 16 | 32'h1);
        rd(A_STAT, v, vo);
        check("R9 R10 other kept", v, stat(1, 1, 0, 1));
      end
    end

    // R7 restart while authenticated
    wr(A_CTRL, 32'h0);
    check("R7 inactive", 32'(dm_active), 0);
    check("R7 auth kept", 32'(authenticated), 1);
    wr(A_CTRL, 32'h0002_0001);
    exp_ch = step(exp_ch); open_ch = step(open_ch);
    check("R7 relocked", 32'(authenticated), 0);
    rd(A_CTRL, v, vo);
    check("R7 sel reset", v, 32'h1);
    check("R7 open sel", vo, 32'h0002_0001);
    rd(A_AUTH, v, vo);
    check("R7 challenge", v, exp_ch);
    check("R7 open challenge", vo, open_ch);
    rd(A_STAT, v, vo);
    check("R7 R10 status", v, stat(0, 0, 0, 1));

    // R4 revocation after unlock
    wr(A_AUTH, exp_ch + SEC);
    check("R3 unlock again", 32'(authenticated), 1);
    wr(A_AUTH, (exp_ch + SEC) ^ 32'h8000_0000);
    exp_ch = step(exp_ch);
    check("R4 revoked", 32'(authenticated), 0);
    wr(7'h05, 32'hDEAD_0005);
    check("R4 R5 rejected after revoke", {resp_err, fwd_valid}, 2'b10);
    rd(A_AUTH, v, vo);
    check("R4 challenge", v, exp_ch);

    finish_run();
  end
endmodule